// File: doc/BRIEF.md
# Ingress Packet Descriptor Finalizer

This block fills in the fields of an ingress packet descriptor that are owned by hardware. It runs after the classifier has produced the descriptor and before the descriptor is written into a notification ring. Packet bytes arrive one per beat, and the first and last beats are flagged. The classifier descriptor, the load balancer's ring choice and the free-running seconds/nanoseconds clock are all sampled on the first beat.

On the last beat the block completes several fields, each one switched on by its own classifier bit:

- the timestamp taken at start of packet;
- a 48-bit packet sequence number;
- a general-purpose sequence number taken from a small bank of counters;
- the notification ring index;
- the ingress one's complement checksum.

Any field whose enable bit is clear is passed through with the classifier's custom content. The finished descriptor leaves the block with a one-cycle valid strobe. A destination code can drop the packet. A dropped packet produces no descriptor and leaves every sequence counter unchanged.

Top module: `pkt_desc_finalizer`

## Requirements
- R1: After reset `desc_valid_o` is low, the packet sequence counter is 0, and all general-purpose counters are 0.
- R2: Classifier inputs, `lb_ring_i` and the time inputs are sampled on the beat that has `beat_sop_i` set. For a delivered packet, `desc_valid_o` is high for exactly the one cycle after the beat that has `beat_eop_i` set. A packet may be a single beat with both flags set.
- R3: With `cls_ts_en_i`=1, `desc_ts_sec_o`/`desc_ts_ns_o` carry the time sampled on the first beat. With it clear, they carry `cls_ts_sec_i`/`cls_ts_ns_i`.
- R4: With `cls_psn_en_i`=1, `desc_psn_o` carries the packet sequence counter. With it clear, `desc_psn_o` carries `cls_psn_i`. In both cases the counter advances by one for each delivered packet.
- R5: With `cls_gp_en_i`=1, bits [2:0] of `cls_gp_i` select one of 8 16-bit counters, and the upper selector bits are ignored. `desc_gp_o` carries that counter's value, and the counter then advances by one. With the enable clear, `desc_gp_o` equals `cls_gp_i` and no counter moves.
- R6: With `cls_ring_keep_i`=1, `desc_ring_o` equals `cls_ring_i`. Otherwise it equals `lb_ring_i`.
- R7: With `cls_csum_en_i`=1, the block swaps the bytes of the seed. It then adds the bytes from offset `cls_csum_start_i` up to the last beat in one's complement, where offset 0 is the first-beat byte. A byte at an even distance from the start is added to bits [15:8] and the next byte to bits [7:0], with end-around carry. The sum is swapped back and output on `desc_csum_o`.
- R8: With `cls_csum_en_i`=0, `desc_csum_o` equals `cls_seed_i` unchanged.
- R9: `cls_dest_i` encodes 00=drop, 01=deliver packet and descriptor, 10=deliver descriptor only, 11=drop. The code of a delivered packet appears on `desc_dest_o`. A dropped packet raises no `desc_valid_o` and changes no sequence counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid_i | input | 1 | A packet byte is present |
| beat_sop_i | input | 1 | This byte is the first of the packet |
| beat_eop_i | input | 1 | This byte is the last of the packet |
| beat_data_i | input | 8 | Packet byte |
| now_sec_i | input | 32 | Free-running time, seconds |
| now_ns_i | input | 32 | Free-running time, nanoseconds |
| cls_ts_en_i | input | 1 | Insert timestamp |
| cls_psn_en_i | input | 1 | Insert packet sequence number |
| cls_gp_en_i | input | 1 | Replace selector with general counter value |
| cls_ring_keep_i | input | 1 | Keep the classifier ring index |
| cls_csum_en_i | input | 1 | Compute checksum |
| cls_dest_i | input | 2 | Destination code |
| cls_ring_i | input | 8 | Classifier ring index |
| lb_ring_i | input | 8 | Load balancer ring choice |
| cls_csum_start_i | input | 8 | Checksum start offset |
| cls_seed_i | input | 16 | Checksum seed / custom bytes |
| cls_gp_i | input | 16 | Counter selector / custom bytes |
| cls_psn_i | input | 48 | Custom bytes in sequence field |
| cls_ts_sec_i | input | 32 | Custom bytes in seconds field |
| cls_ts_ns_i | input | 32 | Custom bytes in nanoseconds field |
| desc_valid_o | output | 1 | Finished descriptor strobe |
| desc_dest_o | output | 2 | Destination code of the descriptor |
| desc_ring_o | output | 8 | Final ring index |
| desc_csum_o | output | 16 | Checksum result or seed |
| desc_gp_o | output | 16 | General sequence field |
| desc_psn_o | output | 48 | Packet sequence field |
| desc_ts_sec_o | output | 32 | Timestamp seconds field |
| desc_ts_ns_o | output | 32 | Timestamp nanoseconds field |

## Verification
The bench runs packets with every enable set and then with every enable clear. Comparing the two shows, field by field, whether inserted hardware values and preserved custom data have been swapped. Checksum packets use a zero start offset, an odd start offset, odd lengths and a single-beat packet. These separate a wrong byte lane, a wrong start position, a lost end-around carry and a missing final swap. Drop codes 00 and 11 are placed between delivered packets that read back both sequence counters, so the tests show whether a drop advanced any counter. Repeated and aliased general selectors show whether only the selected counter moves and whether the upper selector bits are ignored.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

  typedef enum logic [1:0] {
    DEST_DROP     = 2'b00,
    DEST_ALL      = 2'b01,
    DEST_DESC     = 2'b10,
    DEST_DROP_ALT = 2'b11
  } dest_e;

  // one's complement 16-bit add with end-around carry
  function automatic logic [15:0] oc_add16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  // place a byte on the high lane (hi=1) or low lane of a 16-bit word
  function automatic logic [15:0] lane16(input logic [7:0] b, input logic hi);
    return hi ? {b, 8'h00} : {8'h00, b};
  endfunction

  function automatic logic is_delivered(input logic [1:0] code);
    return (code == DEST_ALL) || (code == DEST_DESC);
  endfunction

endpackage

// File: rtl/pdf_csum_acc.sv
module pdf_csum_acc #(
  parameter int OFF_W   = 14,
  parameter int START_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_valid_i,
  input  logic               beat_sop_i,
  input  logic [7:0]         beat_data_i,
  input  logic [START_W-1:0] start_i,
  input  logic [15:0]        seed_i,
  output logic [15:0]        sum_next_o
);
  import pdf_pkg::*;

  localparam logic [OFF_W-1:0] OFF_MAX = {OFF_W{1'b1}};

  logic [15:0]        acc_q;
  logic [OFF_W-1:0]   off_q;
  logic [START_W-1:0] start_q;

  logic [15:0]        base_w;
  logic [OFF_W-1:0]   cur_off_w;
  logic [START_W-1:0] cur_start_w;
  logic               in_span_w;
  logic               hi_lane_w;

  always_comb begin
    base_w      = beat_sop_i ? swap16(seed_i) : acc_q;
    cur_off_w   = beat_sop_i ? '0 : off_q;
    cur_start_w = beat_sop_i ? start_i : start_q;
    in_span_w   = cur_off_w >= OFF_W'(cur_start_w);
    hi_lane_w   = ~(cur_off_w[0] ^ cur_start_w[0]);
    sum_next_o  = in_span_w ? oc_add16(base_w, lane16(beat_data_i, hi_lane_w)) : base_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      off_q   <= '0;
      start_q <= '0;
    end else if (beat_valid_i) begin
      acc_q   <= sum_next_o;
      start_q <= cur_start_w;
      off_q   <= (cur_off_w == OFF_MAX) ? OFF_MAX : cur_off_w + 1'b1;
    end
  end

endmodule

// File: rtl/pdf_seq_bank.sv
module pdf_seq_bank #(
  parameter int PSN_W  = 48,
  parameter int GP_W   = 16,
  parameter int GP_NUM = 8,
  parameter int SEL_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             gp_use_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [PSN_W-1:0] psn_o,
  output logic [GP_W-1:0]  gp_o
);
  localparam int IDX_W = (GP_NUM > 1) ? $clog2(GP_NUM) : 1;

  logic [PSN_W-1:0] psn_q;
  logic [GP_W-1:0]  gp_q [GP_NUM];
  logic [IDX_W-1:0] idx_w;

  assign idx_w = sel_i[IDX_W-1:0];
  assign psn_o = psn_q;
  assign gp_o  = gp_q[idx_w];

  always_ff @(posedge clk) begin
    if (!rst_n) psn_q <= '0;
    else if (fire_i) psn_q <= psn_q + 1'b1;
  end

  for (genvar g = 0; g < GP_NUM; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n) gp_q[g] <= '0;
      else if (fire_i && gp_use_i && (idx_w == IDX_W'(g))) gp_q[g] <= gp_q[g] + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_desc_finalizer.sv
module pkt_desc_finalizer #(
  parameter int PSN_W  = 48,
  parameter int GP_W   = 16,
  parameter int GP_NUM = 8,
  parameter int RING_W = 8,
  parameter int OFF_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid_i,
  input  logic              beat_sop_i,
  input  logic              beat_eop_i,
  input  logic [7:0]        beat_data_i,
  input  logic [31:0]       now_sec_i,
  input  logic [31:0]       now_ns_i,
  input  logic              cls_ts_en_i,
  input  logic              cls_psn_en_i,
  input  logic              cls_gp_en_i,
  input  logic              cls_ring_keep_i,
  input  logic              cls_csum_en_i,
  input  logic [1:0]        cls_dest_i,
  input  logic [RING_W-1:0] cls_ring_i,
  input  logic [RING_W-1:0] lb_ring_i,
  input  logic [7:0]        cls_csum_start_i,
  input  logic [15:0]       cls_seed_i,
  input  logic [GP_W-1:0]   cls_gp_i,
  input  logic [PSN_W-1:0]  cls_psn_i,
  input  logic [31:0]       cls_ts_sec_i,
  input  logic [31:0]       cls_ts_ns_i,
  output logic              desc_valid_o,
  output logic [1:0]        desc_dest_o,
  output logic [RING_W-1:0] desc_ring_o,
  output logic [15:0]       desc_csum_o,
  output logic [GP_W-1:0]   desc_gp_o,
  output logic [PSN_W-1:0]  desc_psn_o,
  output logic [31:0]       desc_ts_sec_o,
  output logic [31:0]       desc_ts_ns_o
);
  import pdf_pkg::*;

  typedef struct packed {
    logic              ts_en;
    logic              psn_en;
    logic              gp_en;
    logic              ring_keep;
    logic              csum_en;
    logic [1:0]        dest;
    logic [RING_W-1:0] ring;
    logic [RING_W-1:0] lb_ring;
    logic [15:0]       seed;
    logic [GP_W-1:0]   gp;
    logic [PSN_W-1:0]  psn;
    logic [31:0]       c_sec;
    logic [31:0]       c_ns;
    logic [31:0]       t_sec;
    logic [31:0]       t_ns;
  } cls_hold_t;

  cls_hold_t hold_q, cur_w, in_w;

  // named internal events for the checker
  logic              sop_w, fin_w, deliver_w, fire_w;
  logic [RING_W-1:0] cur_ring_sel_w;
  logic [PSN_W-1:0]  psn_cur_w;
  logic [GP_W-1:0]   gp_cur_w;
  logic [15:0]       sum_next_w;

  always_comb begin
    in_w = '{ts_en: cls_ts_en_i, psn_en: cls_psn_en_i, gp_en: cls_gp_en_i,
             ring_keep: cls_ring_keep_i, csum_en: cls_csum_en_i, dest: cls_dest_i,
             ring: cls_ring_i, lb_ring: lb_ring_i, seed: cls_seed_i, gp: cls_gp_i,
             psn: cls_psn_i, c_sec: cls_ts_sec_i, c_ns: cls_ts_ns_i,
             t_sec: now_sec_i, t_ns: now_ns_i};
  end

  assign sop_w          = beat_valid_i & beat_sop_i;
  assign cur_w          = sop_w ? in_w : hold_q;
  assign fin_w          = beat_valid_i & beat_eop_i;
  assign deliver_w      = is_delivered(cur_w.dest);
  assign fire_w         = fin_w & deliver_w;
  assign cur_ring_sel_w = cur_w.ring_keep ? cur_w.ring : cur_w.lb_ring;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else if (sop_w) hold_q <= in_w;
  end

  pdf_csum_acc #(.OFF_W(OFF_W), .START_W(8)) u_csum (
    .clk(clk), .rst_n(rst_n),
    .beat_valid_i(beat_valid_i), .beat_sop_i(beat_sop_i),
    .beat_data_i(beat_data_i), .start_i(cls_csum_start_i),
    .seed_i(cls_seed_i), .sum_next_o(sum_next_w)
  );

  pdf_seq_bank #(.PSN_W(PSN_W), .GP_W(GP_W), .GP_NUM(GP_NUM), .SEL_W(GP_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .fire_i(fire_w), .gp_use_i(cur_w.gp_en), .sel_i(cur_w.gp),
    .psn_o(psn_cur_w), .gp_o(gp_cur_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_valid_o  <= 1'b0;
      desc_dest_o   <= '0;
      desc_ring_o   <= '0;
      desc_csum_o   <= '0;
      desc_gp_o     <= '0;
      desc_psn_o    <= '0;
      desc_ts_sec_o <= '0;
      desc_ts_ns_o  <= '0;
    end else begin
      desc_valid_o <= fire_w;
      if (fire_w) begin
        desc_dest_o   <= cur_w.dest;
        desc_ring_o   <= cur_ring_sel_w;
        desc_csum_o   <= cur_w.csum_en ? swap16(sum_next_w) : cur_w.seed;
        desc_gp_o     <= cur_w.gp_en ? gp_cur_w : cur_w.gp;
        desc_psn_o    <= cur_w.psn_en ? psn_cur_w : cur_w.psn;
        desc_ts_sec_o <= cur_w.ts_en ? cur_w.t_sec : cur_w.c_sec;
        desc_ts_ns_o  <= cur_w.ts_en ? cur_w.t_ns : cur_w.c_ns;
      end
    end
  end

endmodule

// File: rtl/pdf_chk.sv
module pdf_chk #(
  parameter int PSN_W  = 48,
  parameter int RING_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid_i,
  input logic              beat_eop_i,
  input logic              fin_w,
  input logic              deliver_w,
  input logic              fire_w,
  input logic [RING_W-1:0] cur_ring_sel_w,
  input logic [PSN_W-1:0]  psn_cur_w,
  input logic              desc_valid_o,
  input logic [RING_W-1:0] desc_ring_o
);

  AST_VALID_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o |-> $past(beat_valid_i && beat_eop_i)); // R2

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_w && !deliver_w) |=> !desc_valid_o); // R9

  AST_PSN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> psn_cur_w == $past(psn_cur_w) + 1'b1); // R4

  AST_PSN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_w |=> $stable(psn_cur_w)); // R9

  AST_RING_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> desc_ring_o == $past(cur_ring_sel_w)); // R6

endmodule

bind pkt_desc_finalizer pdf_chk #(.PSN_W(PSN_W), .RING_W(RING_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .beat_valid_i(beat_valid_i), .beat_eop_i(beat_eop_i),
  .fin_w(fin_w), .deliver_w(deliver_w), .fire_w(fire_w),
  .cur_ring_sel_w(cur_ring_sel_w), .psn_cur_w(psn_cur_w),
  .desc_valid_o(desc_valid_o), .desc_ring_o(desc_ring_o)
);

// File: tb/pkt_desc_finalizer_tb.sv
`timescale 1ns/1ps
module pkt_desc_finalizer_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        beat_valid_i = 0, beat_sop_i = 0, beat_eop_i = 0;
  logic [7:0]  beat_data_i = 0;
  logic [31:0] now_sec_i = 0, now_ns_i = 0;
  logic        cls_ts_en_i = 0, cls_psn_en_i = 0, cls_gp_en_i = 0, cls_ring_keep_i = 0, cls_csum_en_i = 0;
  logic [1:0]  cls_dest_i = 2'b01;
  logic [7:0]  cls_ring_i = 0, lb_ring_i = 0, cls_csum_start_i = 0;
  logic [15:0] cls_seed_i = 0, cls_gp_i = 0;
  logic [47:0] cls_psn_i = 0;
  logic [31:0] cls_ts_sec_i = 0, cls_ts_ns_i = 0;
  logic        desc_valid_o;
  logic [1:0]  desc_dest_o;
  logic [7:0]  desc_ring_o;
  logic [15:0] desc_csum_o, desc_gp_o;
  logic [47:0] desc_psn_o;
  logic [31:0] desc_ts_sec_o, desc_ts_ns_o;

  pkt_desc_finalizer u_dut (.*);

  int checks = 0, errors = 0;
  logic [7:0]  pb [0:31];
  int          plen;
  logic        o_valid;
  logic [1:0]  o_dest;
  logic [7:0]  o_ring;
  logic [15:0] o_csum, o_gp;
  logic [47:0] o_psn;
  logic [31:0] o_sec, o_ns;
  logic [31:0] sop_sec, sop_ns;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference checksum: big-endian 16-bit words from start, deferred fold
  function automatic logic [15:0] ref_csum(input logic [15:0] seed, input int start, input int len);
    int unsigned s;
    s = {16'd0, seed[7:0], seed[15:8]};
    for (int k = start; k < len; k += 2)
      s += {16'd0, pb[k], (k + 1 < len) ? pb[k+1] : 8'h00};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return {s[7:0], s[15:8]};
  endfunction

  // drive plen beats, then sample the cycle after the last beat
  task automatic run_pkt(input logic [31:0] sec, input logic [31:0] ns_base);
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      beat_valid_i = 1; beat_sop_i = (i == 0); beat_eop_i = (i == plen - 1);
      beat_data_i = pb[i]; now_sec_i = sec; now_ns_i = ns_base + i;
    end
    sop_sec = sec; sop_ns = ns_base;
    @(negedge clk);
    beat_valid_i = 0; beat_sop_i = 0; beat_eop_i = 0;
    o_valid = desc_valid_o; o_dest = desc_dest_o; o_ring = desc_ring_o; o_csum = desc_csum_o;
    o_gp = desc_gp_o; o_psn = desc_psn_o; o_sec = desc_ts_sec_o; o_ns = desc_ts_ns_o;
    @(negedge clk);
    chk("R2", "valid is one cycle", {63'd0, desc_valid_o}, 64'd0);
  endtask

  task automatic fill(input int len, input int seedv);
    plen = len;
    for (int i = 0; i < len; i++) pb[i] = 8'((seedv * 37 + i * 91 + 5) & 255);
  endtask

  task automatic set_en(input logic on);
    cls_ts_en_i = on; cls_psn_en_i = on; cls_gp_en_i = on; cls_ring_keep_i = on; cls_csum_en_i = on;
  endtask

  task automatic t_reset;
    chk("R1", "valid after reset", {63'd0, desc_valid_o}, 64'd0);
  endtask

  task automatic t_all_on;
    set_en(1); cls_dest_i = 2'b01; cls_ring_i = 8'h2A; lb_ring_i = 8'h55;
    cls_csum_start_i = 0; cls_seed_i = 16'h0000; cls_gp_i = 16'h0003;
    pb[0] = 8'h12; pb[1] = 8'h34; plen = 2;
    run_pkt(32'h0000_1000, 32'd777);
    chk("R2", "valid after eop", {63'd0, o_valid}, 64'd1);
    chk("R3", "ts sec", {32'd0, o_sec}, {32'd0, sop_sec});
    chk("R3", "ts ns", {32'd0, o_ns}, {32'd0, sop_ns});
    chk("R1", "first psn", {16'd0, o_psn}, 64'd0);
    chk("R5", "gp ctr3 first", {48'd0, o_gp}, 64'd0);
    chk("R6", "ring kept", {56'd0, o_ring}, 64'h2A);
    chk("R7", "csum simple", {48'd0, o_csum}, 64'h3412);
    chk("R9", "dest out", {62'd0, o_dest}, 64'd1);
  endtask

  task automatic t_all_off;
    set_en(0); cls_dest_i = 2'b01; cls_ring_i = 8'h2A; lb_ring_i = 8'h55;
    cls_seed_i = 16'hBEEF; cls_gp_i = 16'h0003; cls_psn_i = 48'hABCD_0123_4567;
    cls_ts_sec_i = 32'hCAFE_0001; cls_ts_ns_i = 32'hCAFE_0002;
    fill(5, 1);
    run_pkt(32'h2000, 32'd50);
    chk("R3", "custom sec kept", {32'd0, o_sec}, 64'hCAFE_0001);
    chk("R3", "custom ns kept", {32'd0, o_ns}, 64'hCAFE_0002);
    chk("R4", "custom psn kept", {16'd0, o_psn}, 64'hABCD_0123_4567);
    chk("R5", "custom gp kept", {48'd0, o_gp}, 64'h0003);
    chk("R6", "lb ring", {56'd0, o_ring}, 64'h55);
    chk("R8", "seed untouched", {48'd0, o_csum}, 64'hBEEF);
  endtask

  task automatic t_counters_after_off;
    set_en(1); cls_gp_i = 16'h0003; fill(3, 2);
    cls_seed_i = 16'h0000; cls_csum_start_i = 0;
    run_pkt(32'h3000, 32'd9);
    chk("R4", "psn advanced by disabled pkt", {16'd0, o_psn}, 64'd2);
    chk("R5", "gp ctr3 not moved while disabled", {48'd0, o_gp}, 64'd1);
  endtask

  task automatic t_drop(input logic [1:0] code);
    set_en(1); cls_dest_i = code; cls_gp_i = 16'h0003; fill(4, 3);
    run_pkt(32'h4000, 32'd1);
    chk("R9", "drop no valid", {63'd0, o_valid}, 64'd0);
    cls_dest_i = 2'b01;
  endtask

  task automatic t_after_drops;
    set_en(1); cls_dest_i = 2'b10; cls_gp_i = 16'h0003; fill(2, 4);
    run_pkt(32'h5000, 32'd3);
    chk("R9", "desc-only valid", {63'd0, o_valid}, 64'd1);
    chk("R9", "desc-only code", {62'd0, o_dest}, 64'd2);
    chk("R9", "psn unchanged by drops", {16'd0, o_psn}, 64'd3);
    chk("R9", "gp unchanged by drops", {48'd0, o_gp}, 64'd2);
    cls_dest_i = 2'b01;
  endtask

  task automatic t_gp_select;
    set_en(1); cls_gp_i = 16'h0005; fill(2, 5);
    run_pkt(32'h6000, 32'd0);
    chk("R5", "gp ctr5 first", {48'd0, o_gp}, 64'd0);
    cls_gp_i = 16'hFFFB; fill(2, 6);
    run_pkt(32'h6001, 32'd0);
    chk("R5", "upper selector bits ignored", {48'd0, o_gp}, 64'd3);
  endtask

  task automatic t_csum_offset;
    set_en(1); cls_csum_start_i = 8'd3; cls_seed_i = 16'h1234; fill(11, 7);
    run_pkt(32'h7000, 32'd0);
    chk("R7", "odd start odd len", {48'd0, o_csum}, {48'd0, ref_csum(16'h1234, 3, 11)});
    cls_csum_start_i = 8'd0; cls_seed_i = 16'hFFF0;
    for (int i = 0; i < 8; i++) pb[i] = 8'hFF;
    plen = 8;
    run_pkt(32'h7001, 32'd0);
    chk("R7", "carry wrap", {48'd0, o_csum}, {48'd0, ref_csum(16'hFFF0, 0, 8)});
    cls_csum_start_i = 8'd20; cls_seed_i = 16'hA1B2; fill(6, 8);
    run_pkt(32'h7002, 32'd0);
    chk("R7", "start past end keeps seed", {48'd0, o_csum}, 64'hA1B2);
  endtask

  task automatic t_single_beat;
    set_en(1); cls_csum_start_i = 0; cls_seed_i = 16'h0102; cls_ring_keep_i = 0; lb_ring_i = 8'h77;
    pb[0] = 8'h40; plen = 1;
    run_pkt(32'h8000, 32'd4242);
    chk("R2", "single beat valid", {63'd0, o_valid}, 64'd1);
    chk("R3", "single beat ts", {32'd0, o_ns}, 64'd4242);
    chk("R7", "single beat csum", {48'd0, o_csum}, {48'd0, ref_csum(16'h0102, 0, 1)});
    chk("R6", "single beat lb ring", {56'd0, o_ring}, 64'h77);
    chk("R4", "psn count", {16'd0, o_psn}, 64'd9);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_all_on();
    t_all_off();
    t_counters_after_off();
    t_drop(2'b00);
    t_drop(2'b11);
    t_after_drops();
    t_gp_select();
    t_csum_offset();
    t_single_beat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule